// File: doc/BRIEF.md
# Token-Arbitrated Serial Sample Output Port

This block is the output stage of one node in a chain of data-collection nodes that share a single serial bus. Filtered samples arrive one channel at a time on a push interface. Each sample is tagged with a status byte when it is pushed, and it is then queued in a small FIFO. Ownership of the bus passes from node to node as a token. When the token reaches a node that has queued data, the node pulls its active-low ready line low. It then shifts one 32-bit word out, most significant bit first, with one bit for each rising edge of an externally supplied serial clock. After the last bit it releases ready and pulses its token output to hand the bus on. A node with nothing queued forwards the token at once.

The status byte holds two things: the modulator error flag of the sample's channel, taken in the push cycle, and a time-break marker. A rising edge on the time-break input arms a delay counted in sample sets. A sample set is the group of words that begins with a channel-0 push. When the delay runs out, every word of one sample set carries the marker. The token and serial-clock inputs come from outside the clock domain, so each passes through a multi-stage synchronizer before edge detection.

Top module: `sdo_token_port`

## Requirements
- R1: After reset, rdy_n is 1, tok_out is 0, ser_dat is 0 and ovf_flag is 0.
- R2: A rising edge on tok_in while the FIFO holds at least one word drives rdy_n low on the third rising clock edge after tok_in rises, and removes the head word from the FIFO.
- R3: A rising edge on tok_in while the FIFO is empty produces a tok_out pulse exactly one cycle wide on the third rising clock edge after tok_in rises. rdy_n stays high.
- R4: While rdy_n is low, each rising edge of ser_clk puts the next bit of the word on ser_dat on the third rising clock edge after ser_clk rises, starting with bit 31.
- R5: One clock after the 32nd bit appears, rdy_n returns high. On the following clock, tok_out pulses high for exactly one cycle.
- R6: The word format is: bits 31:24 status, bits 23:0 sample. Within the status byte, bit 7 is the time-break marker, bit 6 is the error flag, bits 5:2 are zero and bits 1:0 hold the channel number.
- R7: The error flag of a word equals chan_err[push_chan] in the cycle the word is pushed.
- R8: With tb_delay = 0, a rising edge on tb_in marks every word of the next sample set. A sample set begins at a push with push_chan = 0.
- R9: With tb_delay = N, the marked set is the (N+1)-th set that begins after the edge. Only that one set is marked.
- R10: Words leave in push order. A push while the FIFO holds DEPTH words is dropped, and ovf_flag rises one cycle later and stays high until reset.
- R11: Rising edges of ser_clk outside a transaction leave ser_dat and the queued words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Queue one sample in this cycle |
| push_chan | input | 2 | Channel number of the pushed sample |
| push_data | input | 24 | Sample value |
| chan_err | input | 4 | Per-channel modulator error flags |
| tb_in | input | 1 | Time-break event, rising edge active |
| tb_delay | input | 8 | Delay in sample sets before the marker is applied |
| tok_in | input | 1 | Token from the previous node (asynchronous) |
| ser_clk | input | 1 | Serial bit clock from the bus master (asynchronous) |
| rdy_n | output | 1 | Active low while this node owns the bus |
| ser_dat | output | 1 | Serial data, MSB first |
| tok_out | output | 1 | Token to the next node, one-cycle pulse |
| ovf_flag | output | 1 | Sticky FIFO overflow indicator |

## Verification
Each asynchronous edge passes two synchronizer flops and one state register. So rdy_n falls, a forwarded token appears, and each new data bit appears on the third rising clock edge after the input rises. rdy_n is then high one clock after the last bit, and tok_out pulses on the clock after that. Status bits are fixed in the push cycle, and ovf_flag rises one clock after a dropped push. The bench drives inputs on falling clock edges and counts exactly that many rising edges before it samples on the next falling edge. The bench also checks the cycle before each due point, where the old value must still hold.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_FIN   = 2'd2,
      ST_HAND  = 2'd3
   } port_state_t;

   localparam int STAT_MARK_BIT = 7;
   localparam int STAT_ERR_BIT  = 6;
endpackage

// File: rtl/sdo_sync.sv
module sdo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   logic [STAGES-1:0] pipe;
   logic              last;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[0] <= 1'b0;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= pipe[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last <= 1'b0;
      else        last <= pipe[STAGES-1];
   end

   assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/sdo_fifo.sv
module sdo_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/sdo_status.sv
module sdo_status
   import sdo_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int STAT_W   = 8,
   parameter int CHAN     = 4,
   parameter int DLY_W    = 8,
   localparam int CH_W    = $clog2(CHAN),
   localparam int WORD_W  = STAT_W + SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_valid,
   input  logic [CH_W-1:0]     push_chan,
   input  logic [SAMPLE_W-1:0] push_data,
   input  logic [CHAN-1:0]     chan_err,
   input  logic                tb_in,
   input  logic [DLY_W-1:0]    tb_delay,
   output logic [WORD_W-1:0]   word
);
   logic             tb_prev, tb_rise;
   logic             armed, mark_set, mark_now, set_start, mark_bit;
   logic [DLY_W-1:0] wait_cnt;
   logic [STAT_W-1:0] stat;

   assign tb_rise   = tb_in & ~tb_prev;
   assign set_start = push_valid && (push_chan == '0);
   assign mark_now  = armed && (wait_cnt == '0);
   assign mark_bit  = set_start ? mark_now : mark_set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tb_prev  <= 1'b0;
         armed    <= 1'b0;
         wait_cnt <= '0;
         mark_set <= 1'b0;
      end else begin
         tb_prev <= tb_in;
         if (set_start) begin
            mark_set <= mark_now;
            if (armed && !tb_rise) begin
               if (wait_cnt == '0) armed <= 1'b0;
               else                wait_cnt <= wait_cnt - 1'b1;
            end
         end
         if (tb_rise) begin
            armed    <= 1'b1;
            wait_cnt <= tb_delay;
         end
      end
   end

   always_comb begin
      stat                = '0;
      stat[CH_W-1:0]      = push_chan;
      stat[STAT_ERR_BIT]  = chan_err[push_chan];
      stat[STAT_MARK_BIT] = mark_bit;
   end

   assign word = {stat, push_data};
endmodule

// File: rtl/sdo_shifter.sv
module sdo_shifter
   import sdo_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_rise,
   input  logic              ser_rise,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] head,
   output logic              fifo_pop,
   output logic              rdy_n,
   output logic              ser_dat,
   output logic              tok_out
);
   localparam int BC_W = $clog2(WORD_W);

   port_state_t       state;
   logic [WORD_W-1:0] sr;
   logic [BC_W-1:0]   bcnt;

   assign fifo_pop = (state == ST_IDLE) && tok_rise && !fifo_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sr      <= '0;
         bcnt    <= '0;
         rdy_n   <= 1'b1;
         ser_dat <= 1'b0;
         tok_out <= 1'b0;
      end else begin
         tok_out <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (tok_rise) begin
                  if (!fifo_empty) begin
                     sr    <= head;
                     bcnt  <= '0;
                     rdy_n <= 1'b0;
                     state <= ST_SHIFT;
                  end else begin
                     tok_out <= 1'b1;
                  end
               end
            end
            ST_SHIFT: begin
               if (ser_rise) begin
                  ser_dat <= sr[WORD_W-1];
                  sr      <= {sr[WORD_W-2:0], 1'b0};
                  if (bcnt == BC_W'(WORD_W - 1)) state <= ST_FIN;
                  else                           bcnt  <= bcnt + 1'b1;
               end
            end
            ST_FIN: begin
               rdy_n <= 1'b1;
               state <= ST_HAND;
            end
            default: begin
               tok_out <= 1'b1;
               state   <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/sdo_token_port.sv
module sdo_token_port #(
   parameter int SAMPLE_W    = 24,
   parameter int STAT_W      = 8,
   parameter int DEPTH       = 4,
   parameter int CHAN        = 4,
   parameter int DLY_W       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(CHAN),
   localparam int WORD_W     = STAT_W + SAMPLE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_valid,
   input  logic [CH_W-1:0]     push_chan,
   input  logic [SAMPLE_W-1:0] push_data,
   input  logic [CHAN-1:0]     chan_err,
   input  logic                tb_in,
   input  logic [DLY_W-1:0]    tb_delay,
   input  logic                tok_in,
   input  logic                ser_clk,
   output logic                rdy_n,
   output logic                ser_dat,
   output logic                tok_out,
   output logic                ovf_flag
);
   if (STAT_W < 8 || CH_W > 6) begin : g_bad_stat
      initial $fatal(1, "status byte too narrow for channel field");
   end
   if (DEPTH < 2) begin : g_bad_depth
      initial $fatal(1, "FIFO depth must be at least 2");
   end
   if (CHAN < 2) begin : g_bad_chan
      initial $fatal(1, "at least two channels required");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "synchronizer needs two or more stages");
   end

   logic              tok_rise, ser_rise;
   logic              fifo_empty, fifo_full, fifo_pop;
   logic [WORD_W-1:0] in_word, head_word;

   sdo_sync #(.STAGES(SYNC_STAGES)) u_tok_sync (
      .clk(clk), .rst_n(rst_n), .d(tok_in), .rise(tok_rise)
   );

   sdo_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .rise(ser_rise)
   );

   sdo_status #(
      .SAMPLE_W(SAMPLE_W), .STAT_W(STAT_W), .CHAN(CHAN), .DLY_W(DLY_W)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_chan(push_chan),
      .push_data(push_data), .chan_err(chan_err), .tb_in(tb_in),
      .tb_delay(tb_delay), .word(in_word)
   );

   sdo_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_valid), .din(in_word),
      .pop(fifo_pop), .dout(head_word), .empty(fifo_empty),
      .full(fifo_full), .ovf(ovf_flag)
   );

   sdo_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tok_rise(tok_rise), .ser_rise(ser_rise),
      .fifo_empty(fifo_empty), .head(head_word), .fifo_pop(fifo_pop),
      .rdy_n(rdy_n), .ser_dat(ser_dat), .tok_out(tok_out)
   );
endmodule

// File: rtl/sdo_token_port_chk.sv
module sdo_token_port_chk (
   input logic clk,
   input logic rst_n,
   input logic rdy_n,
   input logic tok_out,
   input logic ovf_flag,
   input logic ser_dat,
   input logic tok_rise,
   input logic fifo_empty,
   input logic fifo_full,
   input logic push_valid
);
   p_rdy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(tok_rise && !fifo_empty));

   p_tok_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |=> !tok_out);

   p_tok_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tok_out |-> rdy_n);

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && fifo_full) |=> ovf_flag);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_n |=> $stable(ser_dat));
endmodule

bind sdo_token_port sdo_token_port_chk u_chk (.*);

// File: tb/sdo_token_port_test.sv
module sdo_token_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [1:0]  push_chan = '0;
   logic [23:0] push_data = '0;
   logic [3:0]  chan_err = '0;
   logic        tb_in = 1'b0;
   logic [7:0]  tb_delay = '0;
   logic        tok_in = 1'b0;
   logic        ser_clk = 1'b0;
   logic        rdy_n, ser_dat, tok_out, ovf_flag;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q [$];

   always #10 clk = ~clk;

   sdo_token_port uut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_chan(push_chan),
      .push_data(push_data), .chan_err(chan_err), .tb_in(tb_in),
      .tb_delay(tb_delay), .tok_in(tok_in), .ser_clk(ser_clk),
      .rdy_n(rdy_n), .ser_dat(ser_dat), .tok_out(tok_out), .ovf_flag(ovf_flag)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   // driver: push one sample and queue its expected word
   task automatic push_word(input logic [1:0] ch, input logic [23:0] d,
                            input logic [3:0] errs, input logic mark, input bit keep);
      push_valid = 1'b1;
      push_chan  = ch;
      push_data  = d;
      chan_err   = errs;
      if (keep) exp_q.push_back({mark, errs[ch], 4'b0000, ch, d});
      step(1);
      push_valid = 1'b0;
   endtask

   task automatic pulse_tb(input logic [7:0] dly);
      tb_delay = dly;
      tb_in = 1'b1;
      step(1);
      tb_in = 1'b0;
      step(1);
   endtask

   // monitor: take the bus, collect 32 bits, compare with scoreboard head
   task automatic run_txn(input string tag);
      logic [31:0] got, exp;
      got = '0;
      tok_in = 1'b1;
      step(2);
      chk("R2 ready not yet low", {31'b0, rdy_n}, 32'd1);
      step(1);
      chk("R2 ready low", {31'b0, rdy_n}, 32'd0);
      tok_in = 1'b0;
      for (int b = 0; b < 32; b++) begin
         ser_clk = 1'b1;
         step(3);
         got = {got[30:0], ser_dat};
         if (b != 31) begin
            ser_clk = 1'b0;
            step(3);
         end
      end
      step(1);
      chk("R5 ready released", {31'b0, rdy_n}, 32'd1);
      chk("R5 token not early", {31'b0, tok_out}, 32'd0);
      step(1);
      chk("R5 token pulse", {31'b0, tok_out}, 32'd1);
      step(1);
      chk("R5 token one cycle", {31'b0, tok_out}, 32'd0);
      ser_clk = 1'b0;
      step(3);
      if (exp_q.size() == 0) begin
         checks++;
         errors++;
         $display("FAIL R10 %s: act=word exp=empty queue", tag);
      end else begin
         exp = exp_q.pop_front();
         chk({"R4 R6 ", tag}, got, exp);
      end
   endtask

   task automatic pass_txn(input string tag);
      tok_in = 1'b1;
      step(2);
      chk({"R3 early ", tag}, {31'b0, tok_out}, 32'd0);
      step(1);
      chk({"R3 forward ", tag}, {31'b0, tok_out}, 32'd1);
      chk({"R3 ready high ", tag}, {31'b0, rdy_n}, 32'd1);
      step(1);
      chk({"R3 one cycle ", tag}, {31'b0, tok_out}, 32'd0);
      tok_in = 1'b0;
      step(3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R5 watchdog: act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic hold;
      step(3);
      rst_n = 1'b1;
      step(1);
      chk("R1 rdy_n", {31'b0, rdy_n}, 32'd1);
      chk("R1 tok_out", {31'b0, tok_out}, 32'd0);
      chk("R1 ser_dat", {31'b0, ser_dat}, 32'd0);
      chk("R1 ovf_flag", {31'b0, ovf_flag}, 32'd0);

      // R11: serial clock while idle
      ser_clk = 1'b1; step(3);
      chk("R11 idle clock", {31'b0, ser_dat}, 32'd0);
      ser_clk = 1'b0; step(3);

      // R3: empty pass-through
      pass_txn("empty");

      // R2 R4 R6: plain words
      push_word(2'd1, 24'hA5A5A5, 4'b0000, 1'b0, 1'b1);
      push_word(2'd3, 24'h123456, 4'b0000, 1'b0, 1'b1);
      run_txn("word A");
      hold = ser_dat;
      ser_clk = 1'b1; step(3);
      chk("R11 after txn", {31'b0, ser_dat}, {31'b0, hold});
      ser_clk = 1'b0; step(3);
      run_txn("word B");

      // R7: error flag follows the pushed channel
      push_word(2'd2, 24'h0F0F0F, 4'b0100, 1'b0, 1'b1);
      push_word(2'd1, 24'hF00001, 4'b0100, 1'b0, 1'b1);
      run_txn("R7 err set");
      run_txn("R7 err clear");

      // R8: delay 0 marks next set
      pulse_tb(8'd0);
      for (int c = 0; c < 4; c++) push_word(c[1:0], 24'h800000 + 24'(c), 4'b0000, 1'b1, 1'b1);
      for (int c = 0; c < 4; c++) run_txn("R8 marked set");
      for (int c = 0; c < 4; c++) push_word(c[1:0], 24'h000100 + 24'(c), 4'b0000, 1'b0, 1'b1);
      for (int c = 0; c < 4; c++) run_txn("R8 following set");

      // R9: delay 1 defers by one set, marks one set only
      pulse_tb(8'd1);
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < 4; c++)
            push_word(c[1:0], 24'h7FFFF0 + 24'(s * 4 + c), 4'b0010, (s == 1), 1'b1);
         for (int c = 0; c < 4; c++) run_txn("R9 set");
      end

      // R10: overflow drops the newest word, sticky flag
      for (int k = 0; k < 4; k++) push_word(2'd3, 24'h0A0000 + 24'(k), 4'b1000, 1'b0, 1'b1);
      chk("R10 no ovf when full", {31'b0, ovf_flag}, 32'd0);
      push_word(2'd3, 24'hDEAD00, 4'b1000, 1'b0, 1'b0);
      chk("R10 ovf set", {31'b0, ovf_flag}, 32'd1);
      for (int k = 0; k < 4; k++) run_txn("R10 order");
      pass_txn("R10 dropped");
      chk("R10 ovf sticky", {31'b0, ovf_flag}, 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule